// File: doc/BRIEF.md
# Strap-Addressed Two-Register I2C Target

This block is a bus target for a two-wire serial bus in standard or fast mode. It runs on a system clock well above the bus rate and takes raw samples of the clock line and the data line. It pulls the data line low through an open-drain enable. Two byte registers are reachable over the bus: a control byte at sub-address 0 and a fault byte at sub-address 1. The logic that uses those bytes reads them from output ports and sees each bus write as a one-cycle strobe carrying the register index.

The 7-bit bus address comes from two strap inputs that each have three levels: tied low, tied high or left open. The straps are captured once, just after reset, and are not read again. To address a register, the host first writes a sub-address. It then sends data bytes, or issues a repeated START and reads. For a set time after reset the target ignores the bus completely, so that a host cannot reach it before it has settled.

Top module: `strap_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper 7 bits equal 0x60 + 3*L(strapMsb) + L(strapLsb). L is 0 for strap code 2'b00 (low), 2 for code 2'b01 (high) and 1 for codes 2'b10 or 2'b11 (open). Any other address is left unacknowledged.
- R2: The strap codes are captured on the first clock after reset is released. Later changes on the strap inputs do not change the address the target answers to.
- R3: A write is START, address with bit 0 = 0, a sub-address byte, then data bytes. Each of these bytes is acknowledged. A data byte lands in the selected register (sub-address 0 drives regCtrl, 1 drives regFault) at the falling SCL edge that ends its acknowledge bit. wrStb pulses for one cycle at that point, with wrIdx giving the register index.
- R4: After a sub-address write, a repeated START followed by the address with bit 0 = 1 returns the selected register, MSB first. Reads do not advance the register pointer. A NACK from the host ends the read.
- R5: The target changes its SDA drive only while SCL is low.
- R6: A data byte cut short by a STOP or a START writes nothing, and no strobe is produced.
- R7: Reset clears both registers to 0x00, sets the register pointer to 0 and releases SDA.
- R8: START conditions that occur within HOLDOFF_CYCLES clocks of reset release (3000 by default, which is 60 µs at 50 MHz) are ignored and draw no acknowledge.
- R9: The general call address byte 0x00 is never acknowledged.
- R10: The register pointer advances after each data byte written in one transaction and wraps from sub-address 1 to sub-address 0.
- R11: A sub-address byte above 1 is not acknowledged. Further bytes in that transaction are not acknowledged and write nothing.
- R12: A pulse that lasts a single system clock on SCL or SDA is filtered out. It neither clocks a bit nor forms a START or STOP condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the bus bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw bus clock line level |
| sdaIn | input | 1 | Raw bus data line level |
| sdaDrive | output | 1 | 1 = pull the data line low (open-drain enable) |
| strapMsb | input | 2 | Upper address strap code: 00 low, 01 high, 1x open |
| strapLsb | input | 2 | Lower address strap code: 00 low, 01 high, 1x open |
| regCtrl | output | 8 | Control register (sub-address 0) |
| regFault | output | 8 | Fault register (sub-address 1) |
| wrStb | output | 1 | One-cycle pulse after a register is written from the bus |
| wrIdx | output | 1 | Index of the register written with wrStb |

## Verification
A corrupt bit counter or a stuck state register shows up on the bus within one byte. The acknowledge lands one clock early or late, or goes missing, and the next read returns a shifted byte. A bad register pointer shows up on regCtrl or regFault at the end of the next acknowledged data byte, and on wrIdx in the same cycle. Because the straps are latched only once, a wrong address latch shows up at the first transaction after reset: the target acknowledges the wrong address, or none.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftRx;
    logic loadTx;
    logic shiftTx;
    logic setPtr;
    logic writeReg;
  } dpStrobe_t;

  // three-level strap code to level 0 (low), 1 (open), 2 (high)
  function automatic logic [1:0] strapLevel(input logic [1:0] code);
    case (code)
      2'b00:   strapLevel = 2'd0;
      2'b01:   strapLevel = 2'd2;
      default: strapLevel = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lineOut
);
  localparam int HALF = TAPS / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [TAPS-1:0]        winQ;

  // idle bus level is high, so reset everything high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      winQ    <= '1;
      lineOut <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], rawIn};
      winQ    <= {winQ[TAPS-2:0], syncQ[SYNC_STAGES-1]};
      lineOut <= ($countones(winQ) > HALF);
    end
  end

endmodule

// File: rtl/i2c_target_dp.sv
module i2c_target_dp
  import i2c_target_pkg::*;
#(
  parameter int         NUM_REGS  = 2,
  parameter logic [6:0] ADDR_BASE = 7'h60,
  localparam int        PTR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdaF,
  input  dpStrobe_t                  strb,
  input  logic [1:0]                 strapMsb,
  input  logic [1:0]                 strapLsb,
  output logic                       bitCnt8,
  output logic                       rxLsb,
  output logic                       addrMatch,
  output logic                       ptrValid,
  output logic                       txBit,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat,
  output logic                       wrStb,
  output logic [PTR_W-1:0]           wrIdx
);
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [3:0]        bitCnt;
  logic [PTR_W-1:0]  ptr;
  logic              strapTaken;
  logic [6:0]        devAddr;
  logic [3:0]        strapIdx;
  logic [BYTE_W-1:0] regFile [NUM_REGS];

  assign bitCnt8   = (bitCnt == 4'd8);
  assign rxLsb     = rxShift[0];
  assign txBit     = txShift[BYTE_W-1];
  assign addrMatch = strapTaken && (rxShift[7:1] == devAddr);
  assign ptrValid  = (int'(rxShift) < NUM_REGS);
  assign strapIdx  = {2'b00, strapLevel(strapMsb)} * 4'd3 + {2'b00, strapLevel(strapLsb)};

  // strap capture, once per reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapTaken <= 1'b0;
      devAddr    <= ADDR_BASE;
    end else if (!strapTaken) begin
      strapTaken <= 1'b1;
      devAddr    <= ADDR_BASE + {3'b000, strapIdx};
    end
  end

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else begin
      if (strb.shiftRx) rxShift <= {rxShift[BYTE_W-2:0], sdaF};
      if (strb.clrBits)                 bitCnt <= '0;
      else if (strb.shiftRx && !bitCnt8) bitCnt <= bitCnt + 4'd1;
    end
  end

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= '1;
    else if (strb.loadTx)  txShift <= regFile[ptr];
    else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
  end

  // pointer, register file, write strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr   <= '0;
      wrStb <= 1'b0;
      wrIdx <= '0;
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      wrStb <= strb.writeReg;
      if (strb.setPtr) ptr <= rxShift[PTR_W-1:0];
      if (strb.writeReg) begin
        regFile[ptr] <= rxShift;
        wrIdx        <= ptr;
        ptr          <= (ptr == PTR_W'(NUM_REGS - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regFlat[g*BYTE_W +: BYTE_W] = regFile[g];
  end

  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeReg |=> $stable(regFlat));

  assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strapTaken && $past(strapTaken)) |-> $stable(devAddr));

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_target_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 3000,
  localparam int HOLD_W = $clog2(HOLDOFF_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic      bitCnt8,
  input  logic      rxLsb,
  input  logic      addrMatch,
  input  logic      ptrValid,
  input  logic      txBit,
  output dpStrobe_t strb,
  output logic      sdaDrive
);
  tgtState_t   state, nextState;
  logic        sclPrev, sdaPrev;
  logic        sclRise, sclFall, startEv, stopEv;
  logic [HOLD_W-1:0] holdCnt;
  logic        holdBusy;

  assign holdBusy = (holdCnt != HOLD_W'(HOLDOFF_CYCLES));
  assign sclRise  = sclF && !sclPrev;
  assign sclFall  = !sclF && sclPrev;
  assign startEv  = sclF && sclPrev && sdaPrev && !sdaF;
  assign stopEv   = sclF && sclPrev && !sdaPrev && sdaF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      holdCnt <= '0;
    end else begin
      state   <= nextState;
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      if (holdBusy) holdCnt <= holdCnt + 1'b1;
    end
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (!holdBusy && startEv) begin
      nextState    = ST_ADDR;
      strb.clrBits = 1'b1;
    end else if (!holdBusy && stopEv) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          strb.shiftRx = sclRise;
          if (sclFall && bitCnt8) nextState = addrMatch ? ST_ADDR_ACK : ST_WAIT;
        end
        ST_ADDR_ACK: if (sclFall) begin
          strb.clrBits = 1'b1;
          if (rxLsb) begin
            strb.loadTx = 1'b1;
            nextState   = ST_RD;
          end else begin
            nextState = ST_SUB;
          end
        end
        ST_SUB: begin
          strb.shiftRx = sclRise;
          if (sclFall && bitCnt8) nextState = ptrValid ? ST_SUB_ACK : ST_WAIT;
        end
        ST_SUB_ACK: if (sclFall) begin
          strb.setPtr  = 1'b1;
          strb.clrBits = 1'b1;
          nextState    = ST_WR;
        end
        ST_WR: begin
          strb.shiftRx = sclRise;
          if (sclFall && bitCnt8) nextState = ST_WR_ACK;
        end
        ST_WR_ACK: if (sclFall) begin
          strb.writeReg = 1'b1;
          strb.clrBits  = 1'b1;
          nextState     = ST_WR;
        end
        ST_RD: begin
          strb.shiftRx = sclRise;
          if (sclFall) begin
            if (bitCnt8) nextState = ST_RD_ACK;
            else         strb.shiftTx = 1'b1;
          end
        end
        ST_RD_ACK: begin
          strb.shiftRx = sclRise;
          if (sclFall) begin
            if (rxLsb) nextState = ST_WAIT;
            else begin
              strb.loadTx  = 1'b1;
              strb.clrBits = 1'b1;
              nextState    = ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sdaDrive = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) ||
               (state == ST_WR_ACK) || ((state == ST_RD) && !txBit);
  end

  assert_drive_scl_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrive) |-> !sclF);

  assert_holdoff_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    holdBusy |-> (state == ST_IDLE));

endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
  import i2c_target_pkg::*;
#(
  parameter int         HOLDOFF_CYCLES = 3000,
  parameter int         SYNC_STAGES    = 2,
  parameter int         FILTER_TAPS    = 3,
  parameter logic [6:0] ADDR_BASE      = 7'h60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDrive,
  input  logic [1:0] strapMsb,
  input  logic [1:0] strapLsb,
  output logic [7:0] regCtrl,
  output logic [7:0] regFault,
  output logic       wrStb,
  output logic       wrIdx
);
  localparam int NUM_REGS = 2;
  localparam int LINES    = 2;

  logic [LINES-1:0] rawLine, filtLine;
  dpStrobe_t        strb;
  logic             bitCnt8, rxLsb, addrMatch, ptrValid, txBit;
  logic [NUM_REGS*BYTE_W-1:0] regFlat;

  assign rawLine = {sdaIn, sclIn};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILTER_TAPS)) i_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLine[l]), .lineOut(filtLine[l]));
  end

  i2c_target_ctrl #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclF(filtLine[0]), .sdaF(filtLine[1]),
    .bitCnt8(bitCnt8), .rxLsb(rxLsb), .addrMatch(addrMatch),
    .ptrValid(ptrValid), .txBit(txBit), .strb(strb), .sdaDrive(sdaDrive));

  i2c_target_dp #(.NUM_REGS(NUM_REGS), .ADDR_BASE(ADDR_BASE)) i_dp (
    .clk(clk), .rstN(rstN), .sdaF(filtLine[1]), .strb(strb),
    .strapMsb(strapMsb), .strapLsb(strapLsb), .bitCnt8(bitCnt8),
    .rxLsb(rxLsb), .addrMatch(addrMatch), .ptrValid(ptrValid),
    .txBit(txBit), .regFlat(regFlat), .wrStb(wrStb), .wrIdx(wrIdx));

  assign regCtrl  = regFlat[7:0];
  assign regFault = regFlat[15:8];

endmodule

// File: tb/test_strap_i2c_target.sv
module test_strap_i2c_target;
  localparam int CLK_PERIOD = 20;
  localparam int H          = 10;
  localparam int HOLD       = 3000;

  // {strapMsb, strapLsb, expected 7-bit address}
  localparam logic [10:0] STRAP_TAB [9] = '{
    {2'b00, 2'b00, 7'h60}, {2'b00, 2'b10, 7'h61}, {2'b00, 2'b01, 7'h62},
    {2'b11, 2'b00, 7'h63}, {2'b10, 2'b10, 7'h64}, {2'b10, 2'b01, 7'h65},
    {2'b01, 2'b00, 7'h66}, {2'b01, 2'b11, 7'h67}, {2'b01, 2'b01, 7'h68}};

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSdaLow = 1'b0;
  logic [1:0] strapMsb = 2'b00, strapLsb = 2'b00;
  logic sdaDrive, sdaBus, wrStb, wrIdx;
  logic [7:0] regCtrl, regFault;
  int errors = 0, total = 0, strbCnt = 0, r5Viol = 0;

  assign sdaBus = !(mSdaLow || sdaDrive);

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_i2c_target i_strap_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaDrive(sdaDrive),
    .strapMsb(strapMsb), .strapLsb(strapLsb), .regCtrl(regCtrl),
    .regFault(regFault), .wrStb(wrStb), .wrIdx(wrIdx));

  logic drvPrev = 1'b0;
  always @(negedge clk) begin
    if (wrStb) strbCnt++;
    if (rstN && (sdaDrive != drvPrev) && mScl) r5Viol++;
    drvPrev <= sdaDrive;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic startC;
    mSdaLow = 1'b0; mScl = 1'b1; tick(H);
    mSdaLow = 1'b1; tick(H);
    mScl = 1'b0; tick(H);
  endtask

  task automatic repStart;
    mSdaLow = 1'b0; tick(H);
    mScl = 1'b1; tick(H);
    mSdaLow = 1'b1; tick(H);
    mScl = 1'b0; tick(H);
  endtask

  task automatic stopC;
    mSdaLow = 1'b1; tick(H);
    mScl = 1'b1; tick(H);
    mSdaLow = 1'b0; tick(H);
  endtask

  task automatic sendBit(input logic b, input logic g);
    tick(2);
    mSdaLow = !b;
    if (g) begin
      tick(2); mScl = 1'b1; tick(1); mScl = 1'b0; tick(H - 5);
    end else tick(H - 2);
    mScl = 1'b1;
    if (g && b) begin
      tick(3); mSdaLow = 1'b1; tick(1); mSdaLow = 1'b0; tick(H - 4);
    end else tick(H);
    mScl = 1'b0;
  endtask

  task automatic wByte(input logic [7:0] b, input logic g, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i], g && (i == 7));
    tick(2); mSdaLow = 1'b0; tick(H - 2);
    mScl = 1'b1; tick(H/2);
    ack = !sdaBus;
    tick(H/2); mScl = 1'b0;
  endtask

  task automatic rByte(input logic hostAck, output logic [7:0] b);
    mSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(H); mScl = 1'b1; tick(H/2);
      b[i] = sdaBus;
      tick(H/2); mScl = 1'b0;
    end
    tick(2); mSdaLow = hostAck; tick(H - 2);
    mScl = 1'b1; tick(H); mScl = 1'b0;
    tick(2); mSdaLow = 1'b0;
  endtask

  task automatic doReset;
    rstN = 1'b0; tick(4); rstN = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [6:0] ad;
    logic [7:0] d, rd, rd2;
    int sc;

    // table walk: every strap combination, write and read back
    for (int i = 0; i < 9; i++) begin
      strapMsb = STRAP_TAB[i][10:9];
      strapLsb = STRAP_TAB[i][8:7];
      ad = STRAP_TAB[i][6:0];
      d = 8'h30 + 8'(i * 7);
      doReset; tick(HOLD + 20);
      startC; wByte({ad, 1'b0}, 1'b0, a0); wByte(8'h00, 1'b0, a1);
      wByte(d, 1'b0, a2); stopC;
      chk("R1", "own address acked", a0, 1'b1);
      chk("R3", "ctrl written", regCtrl, d);
      startC; wByte({ad + 7'd1, 1'b0}, 1'b0, a3); stopC;
      chk("R1", "other address nacked", a3, 1'b0);
      startC; wByte({ad, 1'b0}, 1'b0, a0); wByte(8'h00, 1'b0, a1);
      repStart; wByte({ad, 1'b1}, 1'b0, a2); rByte(1'b1, rd); stopC;
      chk("R4", "read back ctrl", rd, d);
    end

    // reset state (R7)
    doReset; tick(1);
    chk("R7", "sda released", sdaDrive, 1'b0);
    chk("R7", "ctrl reset", regCtrl, 8'h00);
    chk("R7", "fault reset", regFault, 8'h00);

    // START during hold-off ignored (R8)
    tick(20);
    startC; wByte({7'h68, 1'b0}, 1'b0, a0); stopC;
    chk("R8", "start in holdoff ignored", a0, 1'b0);
    tick(HOLD);
    startC; wByte({7'h68, 1'b0}, 1'b0, a0); wByte(8'h00, 1'b0, a1);
    wByte(8'h22, 1'b0, a2); stopC;
    chk("R8", "ack after holdoff", a0, 1'b1);
    chk("R3", "ctrl 22", regCtrl, 8'h22);

    // strap change after capture (R2)
    strapMsb = 2'b00; strapLsb = 2'b00;
    startC; wByte({7'h68, 1'b0}, 1'b0, a0); stopC;
    chk("R2", "latched address still acked", a0, 1'b1);
    startC; wByte({7'h60, 1'b0}, 1'b0, a0); stopC;
    chk("R2", "new strap address nacked", a0, 1'b0);

    // general call (R9)
    startC; wByte(8'h00, 1'b0, a0); stopC;
    chk("R9", "general call nacked", a0, 1'b0);

    // auto-increment with wrap (R10)
    sc = strbCnt;
    startC; wByte({7'h68, 1'b0}, 1'b0, a0); wByte(8'h01, 1'b0, a1);
    wByte(8'h11, 1'b0, a2); wByte(8'h44, 1'b0, a2); wByte(8'h33, 1'b0, a3); stopC;
    chk("R10", "fault after wrap", regFault, 8'h33);
    chk("R10", "ctrl second byte", regCtrl, 8'h44);
    chk("R10", "three strobes", strbCnt - sc, 3);
    chk("R10", "last strobe index", wrIdx, 1'b1);

    // read fault, two bytes, pointer does not move (R4)
    startC; wByte({7'h68, 1'b0}, 1'b0, a0); wByte(8'h01, 1'b0, a1);
    repStart; wByte({7'h68, 1'b1}, 1'b0, a2);
    rByte(1'b1, rd); rByte(1'b0, rd2); stopC;
    chk("R4", "read fault", rd, 8'h33);
    chk("R4", "second read same register", rd2, 8'h33);

    // partial byte then STOP (R6)
    sc = strbCnt;
    startC; wByte({7'h68, 1'b0}, 1'b0, a0); wByte(8'h00, 1'b0, a1);
    for (int i = 0; i < 5; i++) sendBit(1'b1, 1'b0);
    stopC;
    chk("R6", "ctrl unchanged", regCtrl, 8'h44);
    chk("R6", "no strobe", strbCnt - sc, 0);

    // bad sub-address (R11)
    sc = strbCnt;
    startC; wByte({7'h68, 1'b0}, 1'b0, a0); wByte(8'h02, 1'b0, a1);
    wByte(8'h99, 1'b0, a2); stopC;
    chk("R11", "sub 2 nacked", a1, 1'b0);
    chk("R11", "data after bad sub nacked", a2, 1'b0);
    chk("R11", "no write", strbCnt - sc, 0);
    chk("R11", "ctrl unchanged", regCtrl, 8'h44);
    chk("R11", "fault unchanged", regFault, 8'h33);

    // single-cycle glitches on both lines (R12)
    startC; wByte({7'h68, 1'b0}, 1'b0, a0); wByte(8'h00, 1'b0, a1);
    wByte(8'hA5, 1'b1, a2); stopC;
    chk("R12", "glitched byte acked", a2, 1'b1);
    chk("R12", "glitched byte intact", regCtrl, 8'hA5);

    chk("R5", "drive changes with SCL high", r5Viol, 0);

    $display("  Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule